// File: doc/BRIEF.md
# Cache Freeze and Line Write-Back Sequencer

This block controls the maintenance side of a data cache. Software programs a starting address and a length counted in cache lines, then starts a write-back. The block walks the selected lines one by one and, for every line marked dirty, sends a line request toward external memory and waits for the acknowledge before clearing that line's dirty flag. Clean lines are passed over in a single cycle each. The contents of the cache are represented only by a per-line dirty bitmap. Master writes that complete inside the cache region set bits in it.

A second function freezes the cache so that no master can touch a line while it is being written back. Software raises a freeze enable. The block then holds every new access that falls inside the cache region, lets accesses already in flight finish, and reports through a done flag that the cache is quiet. Clearing the enable releases the held accesses, and the done flag falls once normal service has resumed. The intended software sequence is: program address and size, freeze, wait for done, start the write-back, wait for it to finish, unfreeze, wait for done to fall.

Top module: `cache_sync_unit`

## Requirements
- R1: After reset every control register reads 0, no master is stalled or acknowledged, and no line request is raised.
- R2: Register 0 holds the start address aligned down to the line size (its low log2(line bytes) bits read 0). Register 1 holds the line count in its low 16 bits.
- R3: Writing register 2 with bit 0 set while no write-back is running starts one. During the run bit 0 reads 1 and bit 1 (finished) reads 0. At the end bit 0 reads 0 and bit 1 reads 1.
- R4: Within the range, one line request is raised per dirty line in ascending line order. Its address is the line's base address, and request and address stay unchanged until acknowledged. The acknowledge clears the line's dirty flag, so repeating the same range raises no request.
- R5: The range stops at the end of the cache region. A start address outside the region, or a count of 0, raises no request, and bit 1 of register 2 reads 1 from the second cycle after the triggering write.
- R6: While a write-back runs, writes to registers 0 and 1 are ignored.
- R7: Register 3 bit 0 is the freeze enable and bit 1 the freeze mode. A freeze is requested only when bit 0 is 1 and bit 1 is 0. Bit 2 is the frozen flag. When the mode bit is set, the enable stalls nothing and never raises the flag.
- R8: With no region access in flight, the frozen flag reads 1 from the cycle after the write to register 3 takes effect. Otherwise it rises only on the edge after every in-flight region access has completed.
- R9: From the cycle a freeze request is registered until normal service resumes, a new region access is stalled (stall high, no acknowledge). Accesses outside the region proceed.
- R10: After the enable is cleared, the frozen flag falls one edge later. A held access is then accepted on the next edge and completes with its original address, so a held write marks its own line dirty.
- R11: An accepted access acknowledges in a single cycle, exactly two edges after the accepting edge. Only writes inside the region mark their line dirty, and they do so on completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register index (0 address, 1 count, 2 sync control, 3 freeze control) |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr |
| portReq | input | NUM_PORTS | Per-master access request, held until acknowledged |
| portWrite | input | NUM_PORTS | Per-master write qualifier |
| portAddr | input | NUM_PORTS*32 | Per-master byte address, packed |
| portStall | output | NUM_PORTS | Access held by a freeze |
| portAck | output | NUM_PORTS | Access completes this cycle |
| wbReq | output | 1 | Line write-back request |
| wbAddr | output | 32 | Base address of the requested line |
| wbAck | input | 1 | Memory accepted the line |

## Verification
If the dirty bitmap were corrupted, it would show at the request port within the next write-back over the affected range. A line would then be requested twice, skipped, or requested out of order, and the logged request list would differ from the expected count and first address. A freeze state machine that declared itself frozen too early would raise the frozen flag while a master acknowledge was still due. One that released too early would drop a stall before the flag fell, and both are visible within one or two cycles. A wrong line counter would end a run at the wrong line or miss the region boundary, and the next repeat of the range would expose it.

// File: rtl/csu_pkg.sv
package csu_pkg;

  typedef enum logic [1:0] {
    REG_LINE_ADDR = 2'd0,
    REG_LINE_CNT  = 2'd1,
    REG_SYNC_CTL  = 2'd2,
    REG_HOLD_CTL  = 2'd3
  } regSel_e;

  typedef enum logic [1:0] {
    HOLD_RUN    = 2'd0,
    HOLD_DRAIN  = 2'd1,
    HOLD_FROZEN = 2'd2
  } holdState_e;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_SCAN = 2'd1,
    ENG_WAIT = 2'd2
  } engState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic loadRange;
    logic stepLine;
    logic clearLine;
    logic finish;
    logic holdNew;
    logic frozen;
  } csuStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic startHit;
    logic freezeReq;
    logic anyInflight;
    logic lineDirty;
    logic rangeEmpty;
  } csuStatus_t;

endpackage

// File: rtl/csu_port_slot.sv
module csu_port_slot #(
  parameter int ADDR_W = 32,
  parameter int OFF_W = 5,
  parameter int IDX_W = 6,
  parameter int ACC_LAT = 2,
  parameter logic [ADDR_W-1:0] BASE = '0,
  parameter logic [ADDR_W-1:0] REGION_BYTES = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic              holdNew,
  output logic              stall,
  output logic              ack,
  output logic              inflight,
  output logic              markValid,
  output logic [IDX_W-1:0]  markIdx
);

  localparam int CNT_W = $clog2(ACC_LAT + 1);

  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  latIdx;
  logic              latWrite;
  logic              latRegion;
  logic [ADDR_W-1:0] offset;
  logic              inRegion;
  logic              busy;
  logic              accept;

  assign offset   = addr - BASE;
  assign inRegion = (addr >= BASE) && (offset < REGION_BYTES);
  assign busy     = (cnt != '0);
  assign accept   = req && !busy && !(inRegion && holdNew);
  assign stall    = req && !busy && inRegion && holdNew;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt       <= '0;
      latIdx    <= '0;
      latWrite  <= 1'b0;
      latRegion <= 1'b0;
    end else if (accept) begin
      cnt       <= CNT_W'(ACC_LAT);
      latIdx    <= offset[OFF_W +: IDX_W];
      latWrite  <= write && inRegion;
      latRegion <= inRegion;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign ack       = (cnt == CNT_W'(1));
  assign inflight  = busy && latRegion;
  assign markValid = ack && latWrite;
  assign markIdx   = latIdx;

endmodule

// File: rtl/csu_ctrl.sv
module csu_ctrl
  import csu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  csuStatus_t stat,
  input  logic       wbAck,
  output csuStrobe_t strobe,
  output logic       wbReq
);

  holdState_e holdState, holdNext;
  engState_e  engState, engNext;

  always_comb begin
    holdNext = holdState;
    unique case (holdState)
      HOLD_RUN:
        if (stat.freezeReq) holdNext = stat.anyInflight ? HOLD_DRAIN : HOLD_FROZEN;
      HOLD_DRAIN:
        if (!stat.freezeReq)       holdNext = HOLD_RUN;
        else if (!stat.anyInflight) holdNext = HOLD_FROZEN;
      HOLD_FROZEN:
        if (!stat.freezeReq) holdNext = HOLD_RUN;
      default: holdNext = HOLD_RUN;
    endcase
  end

  always_comb begin
    engNext          = engState;
    strobe.loadRange = 1'b0;
    strobe.stepLine  = 1'b0;
    strobe.clearLine = 1'b0;
    strobe.finish    = 1'b0;
    unique case (engState)
      ENG_IDLE:
        if (stat.startHit) begin
          strobe.loadRange = 1'b1;
          engNext = ENG_SCAN;
        end
      ENG_SCAN:
        if (stat.rangeEmpty) begin
          strobe.finish = 1'b1;
          engNext = ENG_IDLE;
        end else if (stat.lineDirty) begin
          engNext = ENG_WAIT;
        end else begin
          strobe.stepLine = 1'b1;
        end
      ENG_WAIT:
        if (wbAck) begin
          strobe.clearLine = 1'b1;
          strobe.stepLine  = 1'b1;
          engNext = ENG_SCAN;
        end
      default: engNext = ENG_IDLE;
    endcase
  end

  assign strobe.holdNew = stat.freezeReq || (holdState != HOLD_RUN);
  assign strobe.frozen  = (holdState == HOLD_FROZEN);
  assign wbReq          = (engState == ENG_WAIT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdState <= HOLD_RUN;
      engState  <= ENG_IDLE;
    end else begin
      holdState <= holdNext;
      engState  <= engNext;
    end
  end

endmodule

// File: rtl/csu_dpath.sv
module csu_dpath
  import csu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINE_BYTES = 32,
  parameter int NUM_LINES = 64,
  parameter int NUM_PORTS = 2,
  parameter int SIZE_W = 16,
  parameter int ACC_LAT = 2,
  parameter logic [ADDR_W-1:0] BASE = '0
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        regWe,
  input  logic [1:0]                  regAddr,
  input  logic [ADDR_W-1:0]           regWdata,
  output logic [ADDR_W-1:0]           regRdata,
  input  logic [NUM_PORTS-1:0]        portReq,
  input  logic [NUM_PORTS-1:0]        portWrite,
  input  logic [NUM_PORTS*ADDR_W-1:0] portAddr,
  output logic [NUM_PORTS-1:0]        portStall,
  output logic [NUM_PORTS-1:0]        portAck,
  output logic [ADDR_W-1:0]           wbAddr,
  input  csuStrobe_t                  strobe,
  output csuStatus_t                  stat,
  output logic                        engBusy,
  output logic                        engDone
);

  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(NUM_LINES);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(LINE_BYTES - 1);
  localparam logic [ADDR_W-1:0] REGION_BYTES = ADDR_W'(NUM_LINES * LINE_BYTES);
  localparam logic [IDX_W:0] LINE_TOTAL = (IDX_W + 1)'(NUM_LINES);

  logic [ADDR_W-1:0]    lineAddrReg;
  logic [SIZE_W-1:0]    lineCountReg;
  logic                 holdEna;
  logic                 holdMode;
  logic [NUM_LINES-1:0] dirty;
  logic [NUM_LINES-1:0] dirtyNext;
  logic [IDX_W-1:0]     curIdx;
  logic [SIZE_W-1:0]    remaining;

  logic [NUM_PORTS-1:0] slotInflight;
  logic [NUM_PORTS-1:0] slotMark;
  logic [IDX_W-1:0]     slotIdx [NUM_PORTS];

  // per-master access slots
  for (genvar p = 0; p < NUM_PORTS; p++) begin : gSlot
    csu_port_slot #(
      .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .ACC_LAT(ACC_LAT),
      .BASE(BASE), .REGION_BYTES(REGION_BYTES)
    ) uSlot (
      .clk(clk), .rstN(rstN),
      .req(portReq[p]), .write(portWrite[p]),
      .addr(portAddr[p*ADDR_W +: ADDR_W]),
      .holdNew(strobe.holdNew),
      .stall(portStall[p]), .ack(portAck[p]),
      .inflight(slotInflight[p]),
      .markValid(slotMark[p]), .markIdx(slotIdx[p])
    );
  end

  // range computation from programmed registers
  logic [ADDR_W-1:0] startOff;
  logic              startIn;
  logic [IDX_W-1:0]  startIdx;
  logic [IDX_W:0]    room;
  logic [SIZE_W-1:0] roomExt;
  logic [SIZE_W-1:0] loadCount;

  assign startOff  = lineAddrReg - BASE;
  assign startIn   = (lineAddrReg >= BASE) && (startOff < REGION_BYTES);
  assign startIdx  = startOff[OFF_W +: IDX_W];
  assign room      = LINE_TOTAL - {1'b0, startIdx};
  assign roomExt   = SIZE_W'(room);
  assign loadCount = !startIn ? '0 : ((lineCountReg < roomExt) ? lineCountReg : roomExt);

  logic wrAddr, wrCount, wrSync, wrHold;
  assign wrAddr  = regWe && (regAddr == REG_LINE_ADDR) && !engBusy;
  assign wrCount = regWe && (regAddr == REG_LINE_CNT) && !engBusy;
  assign wrSync  = regWe && (regAddr == REG_SYNC_CTL);
  assign wrHold  = regWe && (regAddr == REG_HOLD_CTL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineAddrReg  <= '0;
      lineCountReg <= '0;
      holdEna      <= 1'b0;
      holdMode     <= 1'b0;
    end else begin
      if (wrAddr)  lineAddrReg  <= regWdata & ~OFF_MASK;
      if (wrCount) lineCountReg <= regWdata[SIZE_W-1:0];
      if (wrHold) begin
        holdEna  <= regWdata[0];
        holdMode <= regWdata[1];
      end
    end
  end

  // write-back engine state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      engBusy   <= 1'b0;
      engDone   <= 1'b0;
      curIdx    <= '0;
      remaining <= '0;
    end else if (strobe.loadRange) begin
      engBusy   <= 1'b1;
      engDone   <= 1'b0;
      curIdx    <= startIdx;
      remaining <= loadCount;
    end else begin
      if (strobe.finish) begin
        engBusy <= 1'b0;
        engDone <= 1'b1;
      end
      if (strobe.stepLine) begin
        curIdx    <= curIdx + 1'b1;
        remaining <= remaining - 1'b1;
      end
    end
  end

  // dirty bitmap: completion marks win over the engine's clear
  always_comb begin
    dirtyNext = dirty;
    if (strobe.clearLine) dirtyNext[curIdx] = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (slotMark[p]) dirtyNext[slotIdx[p]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) dirty <= '0;
    else       dirty <= dirtyNext;
  end

  always_comb begin
    unique case (regAddr)
      REG_LINE_ADDR: regRdata = lineAddrReg;
      REG_LINE_CNT:  regRdata = ADDR_W'(lineCountReg);
      REG_SYNC_CTL:  regRdata = {{(ADDR_W-2){1'b0}}, engDone, engBusy};
      default:       regRdata = {{(ADDR_W-3){1'b0}}, strobe.frozen, holdMode, holdEna};
    endcase
  end

  assign wbAddr           = BASE + (ADDR_W'(curIdx) << OFF_W);
  assign stat.startHit    = wrSync && regWdata[0] && !engBusy;
  assign stat.freezeReq   = holdEna && !holdMode;
  assign stat.anyInflight = |slotInflight;
  assign stat.lineDirty   = dirty[curIdx];
  assign stat.rangeEmpty  = (remaining == '0);

endmodule

// File: rtl/cache_sync_unit.sv
module cache_sync_unit
  import csu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINE_BYTES = 32,
  parameter int NUM_LINES = 64,
  parameter int NUM_PORTS = 2,
  parameter int SIZE_W = 16,
  parameter int ACC_LAT = 2,
  parameter logic [ADDR_W-1:0] BASE = 32'h0800_0000
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        regWe,
  input  logic [1:0]                  regAddr,
  input  logic [ADDR_W-1:0]           regWdata,
  output logic [ADDR_W-1:0]           regRdata,
  input  logic [NUM_PORTS-1:0]        portReq,
  input  logic [NUM_PORTS-1:0]        portWrite,
  input  logic [NUM_PORTS*ADDR_W-1:0] portAddr,
  output logic [NUM_PORTS-1:0]        portStall,
  output logic [NUM_PORTS-1:0]        portAck,
  output logic                        wbReq,
  output logic [ADDR_W-1:0]           wbAddr,
  input  logic                        wbAck
);

  csuStrobe_t strobe;
  csuStatus_t stat;
  logic       engBusy;
  logic       engDone;
  logic       chkHold;
  logic       chkFrozen;
  logic       chkInflight;

  csu_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .stat(stat), .wbAck(wbAck),
    .strobe(strobe), .wbReq(wbReq)
  );

  csu_dpath #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .NUM_LINES(NUM_LINES),
    .NUM_PORTS(NUM_PORTS), .SIZE_W(SIZE_W), .ACC_LAT(ACC_LAT), .BASE(BASE)
  ) uDpath (
    .clk(clk), .rstN(rstN),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .portReq(portReq), .portWrite(portWrite), .portAddr(portAddr),
    .portStall(portStall), .portAck(portAck),
    .wbAddr(wbAddr), .strobe(strobe), .stat(stat),
    .engBusy(engBusy), .engDone(engDone)
  );

  assign chkHold     = strobe.holdNew;
  assign chkFrozen   = strobe.frozen;
  assign chkInflight = stat.anyInflight;

endmodule

// File: rtl/cache_sync_unit_chk.sv
module cache_sync_unit_chk #(
  parameter int ADDR_W = 32,
  parameter int NUM_PORTS = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 wbReq,
  input logic                 wbAck,
  input logic [ADDR_W-1:0]    wbAddr,
  input logic [NUM_PORTS-1:0] portStall,
  input logic                 holdNew,
  input logic                 frozen,
  input logic                 anyInflight,
  input logic                 engBusy,
  input logic                 engDone
);

  assert_wb_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wbReq && !wbAck) |=> (wbReq && $stable(wbAddr)));

  assert_req_in_run_R3: assert property (@(posedge clk) disable iff (!rstN)
    wbReq |-> engBusy);

  assert_done_end_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(engDone) |-> (!engBusy && $past(engBusy)));

  assert_frozen_drained_R8: assert property (@(posedge clk) disable iff (!rstN)
    frozen |-> !anyInflight);

  assert_frozen_after_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frozen) |-> $past(holdNew));

  assert_stall_needs_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (portStall != '0) |-> holdNew);

endmodule

bind cache_sync_unit cache_sync_unit_chk #(.ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS)) uChk (
  .clk(clk), .rstN(rstN), .wbReq(wbReq), .wbAck(wbAck), .wbAddr(wbAddr),
  .portStall(portStall), .holdNew(chkHold), .frozen(chkFrozen),
  .anyInflight(chkInflight), .engBusy(engBusy), .engDone(engDone)
);

// File: tb/cache_sync_unit_test.sv
module cache_sync_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int NP = 2;
  localparam logic [31:0] BASE = 32'h0800_0000;

  // {start address, line count, expected requests, expected first line (FF = none)}
  localparam logic [63:0] VECS [0:6] = '{
    {32'h0800_0065, 16'd2,  8'd2, 8'd3},
    {32'h0800_0060, 16'd2,  8'd0, 8'hFF},
    {32'h0800_00A0, 16'd10, 8'd1, 8'd10},
    {32'h0800_0780, 16'd10, 8'd1, 8'd63},
    {32'h07FF_FFC0, 16'd8,  8'd0, 8'hFF},
    {32'h0800_0000, 16'd0,  8'd0, 8'hFF},
    {32'h0800_0000, 16'd64, 8'd1, 8'd20}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [NP-1:0] portReq = '0;
  logic [NP-1:0] portWrite = '0;
  logic [NP*ADDR_W-1:0] portAddr = '0;
  logic [NP-1:0] portStall;
  logic [NP-1:0] portAck;
  logic wbReq;
  logic [31:0] wbAddr;
  logic wbAck = 1'b0;

  int total = 0;
  int bad = 0;
  int logCount = 0;
  logic [31:0] logFirst = '0;
  logic [31:0] rd;

  cache_sync_unit uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .portReq(portReq), .portWrite(portWrite), .portAddr(portAddr),
    .portStall(portStall), .portAck(portAck), .wbReq(wbReq), .wbAddr(wbAddr), .wbAck(wbAck)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] lineAt(input int n);
    return BASE + 32'(n * 32);
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // memory side: acknowledge each line request once and log it
  initial begin
    forever begin
      @(negedge clk);
      if (wbAck) wbAck = 1'b0;
      else if (wbReq) begin
        if (logCount == 0) logFirst = wbAddr;
        logCount++;
        wbAck = 1'b1;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] v);
    regAddr = a;
    #1;
    v = regRdata;
  endtask

  task automatic portAccess(input int p, input logic [31:0] a, input logic w);
    @(negedge clk);
    portReq[p] = 1'b1; portWrite[p] = w; portAddr[p*ADDR_W +: ADDR_W] = a;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (portAck[p]) break;
    end
    portReq[p] = 1'b0;
  endtask

  task automatic runSync(input logic [31:0] a, input logic [15:0] n);
    regWrite(2'd0, a);
    regWrite(2'd1, {16'd0, n});
    logCount = 0;
    regWrite(2'd2, 32'd1);
    for (int i = 0; i < 500; i++) begin
      regRead(2'd2, rd);
      if (rd[1]) break;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int r = 0; r < 4; r++) begin
      regRead(2'(r), rd);
      check("R1 register reset", rd, 0);
    end
    check("R1 no stall", portStall, 0);
    check("R1 no ack", portAck, 0);
    check("R1 no line request", wbReq, 0);

    // R2 alignment and count
    regWrite(2'd0, 32'h0800_0065);
    regRead(2'd0, rd);
    check("R2 address aligned down", rd, 32'h0800_0060);
    regWrite(2'd1, 32'd7);
    regRead(2'd1, rd);
    check("R2 line count", rd, 7);

    // R11 latency: accept at first edge, ack in the cycle after the second
    @(negedge clk);
    portReq[0] = 1'b1; portWrite[0] = 1'b1; portAddr[0 +: ADDR_W] = lineAt(3);
    @(negedge clk);
    check("R11 no ack one cycle after accept", portAck[0], 0);
    @(negedge clk);
    check("R11 ack two edges after accept", portAck[0], 1);
    portReq[0] = 1'b0;
    @(negedge clk);
    check("R11 single-cycle ack", portAck[0], 0);

    // dirty lines 4, 10, 20, 63; a read of line 40 leaves it clean
    portAccess(1, lineAt(4), 1'b1);
    portAccess(0, lineAt(10), 1'b1);
    portAccess(1, lineAt(20), 1'b1);
    portAccess(0, lineAt(63), 1'b1);
    portAccess(1, lineAt(40), 1'b0);

    // R4 R5 R3: table of ranges
    for (int v = 0; v < 7; v++) begin
      runSync(VECS[v][63:32], VECS[v][31:16]);
      regRead(2'd2, rd);
      check($sformatf("R3 vec%0d finished flags", v), rd[1:0], 2'b10);
      check($sformatf("R4 vec%0d request count", v), logCount, VECS[v][15:8]);
      if (VECS[v][7:0] != 8'hFF)
        check($sformatf("R4 vec%0d first line address", v), logFirst, lineAt(int'(VECS[v][7:0])));
    end

    // R5 empty range finishes on the second edge after the trigger
    regWrite(2'd0, 32'h0400_0000);
    regWrite(2'd1, 32'd4);
    regWrite(2'd2, 32'd1);
    regRead(2'd2, rd);
    check("R5 empty run busy first cycle", rd[1:0], 2'b01);
    @(negedge clk);
    regRead(2'd2, rd);
    check("R5 empty run done next cycle", rd[1:0], 2'b10);

    // R6 R3: registers locked during a run, finished bit cleared at start
    regWrite(2'd0, BASE);
    regWrite(2'd1, 32'd64);
    regWrite(2'd2, 32'd1);
    regRead(2'd2, rd);
    check("R3 running flags", rd[1:0], 2'b01);
    regWrite(2'd0, BASE + 32'h400);
    regWrite(2'd1, 32'd3);
    regRead(2'd0, rd);
    check("R6 address write ignored", rd, BASE);
    regRead(2'd1, rd);
    check("R6 count write ignored", rd, 64);
    for (int i = 0; i < 500; i++) begin
      regRead(2'd2, rd);
      if (rd[1]) break;
      @(negedge clk);
    end
    regRead(2'd0, rd);
    check("R6 address kept after run", rd, BASE);

    // R7 mode bit set: no freeze effect
    regWrite(2'd3, 32'd3);
    repeat (3) @(negedge clk);
    regRead(2'd3, rd);
    check("R7 mode set never frozen", rd, 3);
    portReq[0] = 1'b1; portWrite[0] = 1'b0; portAddr[0 +: ADDR_W] = lineAt(7);
    #1;
    check("R7 mode set no stall", portStall[0], 0);
    @(negedge clk);
    @(negedge clk);
    check("R7 mode set access acks", portAck[0], 1);
    portReq[0] = 1'b0;
    regWrite(2'd3, 32'd0);

    // R8 freeze with an access in flight
    @(negedge clk);
    portReq[0] = 1'b1; portWrite[0] = 1'b1; portAddr[0 +: ADDR_W] = lineAt(30);
    regWe = 1'b1; regAddr = 2'd3; regWdata = 32'd1;
    @(negedge clk);
    regWe = 1'b0;
    regRead(2'd3, rd);
    check("R8 not frozen at request", rd[2], 0);
    @(negedge clk);
    check("R8 in-flight access acks", portAck[0], 1);
    regRead(2'd3, rd);
    check("R8 not frozen during ack", rd[2], 0);
    portReq[0] = 1'b0;
    @(negedge clk);
    regRead(2'd3, rd);
    check("R8 not frozen on completing edge", rd[2], 0);
    @(negedge clk);
    regRead(2'd3, rd);
    check("R8 frozen after drain", rd[2], 1);

    // R9 stall inside region, pass outside
    portReq[1] = 1'b1; portWrite[1] = 1'b1; portAddr[ADDR_W +: ADDR_W] = lineAt(5);
    portReq[0] = 1'b1; portWrite[0] = 1'b1; portAddr[0 +: ADDR_W] = 32'h0400_0000;
    #1;
    check("R9 region access stalled", portStall[1], 1);
    check("R9 outside access not stalled", portStall[0], 0);
    @(negedge clk);
    @(negedge clk);
    check("R9 outside access acks", portAck[0], 1);
    check("R9 held access no ack", portAck[1], 0);
    portReq[0] = 1'b0;

    // write-back while frozen sees the drained write of line 30
    runSync(lineAt(30), 16'd1);
    check("R8 drained write reached bitmap", logCount, 1);
    check("R4 drained line address", logFirst, lineAt(30));
    check("R9 still stalled", portStall[1], 1);

    // R10 unfreeze
    @(negedge clk);
    regWe = 1'b1; regAddr = 2'd3; regWdata = 32'd0;
    @(negedge clk);
    regWe = 1'b0;
    regRead(2'd3, rd);
    check("R10 flag held one edge", rd[2], 1);
    check("R10 stall until resume", portStall[1], 1);
    @(negedge clk);
    regRead(2'd3, rd);
    check("R10 flag falls", rd[2], 0);
    check("R10 stall released", portStall[1], 0);
    @(negedge clk);
    check("R10 no ack yet", portAck[1], 0);
    @(negedge clk);
    check("R10 held access acks", portAck[1], 1);
    portReq[1] = 1'b0;
    runSync(lineAt(5), 16'd1);
    check("R10 held write kept its address", logCount, 1);
    check("R10 held write line", logFirst, lineAt(5));

    finishRun();
  end

endmodule